// File: doc/BRIEF.md
# Stop Mode and Warm-Up Sequencer

This block parks a small microcontroller in a low-power stop state and brings it back out safely. Software writes a control byte with the stop bit set. The block then gates off the core clock enable and applies a pin policy to the ports: the pins either keep the values they had at entry, or they go to high impedance. The block then waits for a stop-release input, which is either edge-sensitive or level-sensitive. A mandatory warm-up countdown follows, and only when it ends does the core clock enable return.

The countdown steps on the divided tick of whichever clock was driving the system when stop was entered. Software has no say in that choice. A three-way clock gear sets the rate of the core clock enable while running. The oscillator, the wake pins and the voltage monitor sit outside this block and appear as plain digital inputs and tick strobes.

Top module: `stop_wakeup_ctrl`

## Requirements
- R1: After reset the block is running (stopped=0, warming=0, wu_done=0, wu_err=0). The gear is divide-by-4 and the warm-up count register holds 0x66.
- R2: In the running state, a write to address 0 with bit 0 set enters stop on that clock edge, provided the count register is non-zero. While stopped or warming, cpu_ce stays 0, and stopped and warming are never both 1.
- R3: With control bit 1 = 0 (edge wake), the block leaves stop only on a rising edge of rel_in seen while stopped. A rel_in already high at entry does not wake it.
- R4: With control bit 1 = 1 (level wake), the block leaves stop on any clock edge where rel_in is high. A rel_in already high at entry starts the warm-up on the next edge.
- R5: With control bit 2 = 1, port_oe stays 1 while stopped or warming, and port_q holds the port_d value captured at stop entry. With bit 2 = 0, port_oe is 0 while stopped or warming. In the running state, port_oe is 1 and port_q follows port_d.
- R6: On release, the count register value N is loaded. The count drops once per tick of the warm-up source. On the Nth tick, the block returns to running, and wu_done is 1 for exactly one cycle, the first running cycle.
- R7: A stop write while the count register (address 1) holds 0 is refused. The block stays running, and wu_err pulses for one cycle.
- R8: The gear register (address 2, bits 1:0) sets the rate of cpu_ce: code 00 gives 1 enable in 4 clocks, 01 gives 1 in 2, and 10 gives every clock. The divider restarts each time running resumes.
- R9: A gear write with code 11 is ignored, and the previous gear stays in force.
- R10: The warm-up source is the sys_slow value captured at stop entry (1 selects tick_slow, 0 selects tick_fast) and is shown on wu_slow. Control bit 3 has no effect on it.
- R11: Register writes made while stopped or warming are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock fc |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 warm-up count, 2 gear |
| wr_data | input | CW | Write data |
| rel_in | input | 1 | Stop-release request |
| sys_slow | input | 1 | 1 when the slow clock drives the system |
| tick_fast | input | 1 | Divided tick of the fast clock |
| tick_slow | input | 1 | Divided tick of the slow clock |
| port_d | input | PW | Port values driven by the core |
| cpu_ce | output | 1 | Core clock enable (geared) |
| stopped | output | 1 | In stop state |
| warming | output | 1 | Warm-up countdown running |
| wu_done | output | 1 | One-cycle pulse at end of warm-up |
| wu_err | output | 1 | One-cycle pulse on refused stop |
| wu_slow | output | 1 | Warm-up source captured at entry |
| port_q | output | PW | Port values to pins |
| port_oe | output | 1 | Port output enable |

## Verification
On every cycle, the assertions check the following:
- the core enable stays gated off during stop and warm-up;
- the stop and warm-up states never overlap;
- wu_done and wu_err fall only in the running state;
- a held port value and the warm-up source do not move mid-sequence;
- warm-up is only ever entered from stop.

Other behaviours appear only through the bench's scenarios and its cycle-accurate reference model: the difference between edge and level wake when release is already high at entry, the exact warm-up length for a given count and tick source, the gear rates, the ignored reserved code, and the writes ignored while halted.

// File: rtl/stop_wakeup_ctrl.sv
module stop_wakeup_ctrl #(
  parameter int PW = 4,
  parameter int CW = 8,
  parameter logic [CW-1:0] WU_INIT = CW'('h66)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          rel_in,
  input  logic          sys_slow,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic [PW-1:0] port_d,
  output logic          cpu_ce,
  output logic          stopped,
  output logic          warming,
  output logic          wu_done,
  output logic          wu_err,
  output logic          wu_slow,
  output logic [PW-1:0] port_q,
  output logic          port_oe
);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WARM} st_t;

  st_t           st;
  logic          lvl_mode, hold_pins, rel_q;
  logic [1:0]    gear, div;
  logic [CW-1:0] wu_cnt, cnt;
  logic [PW-1:0] pin_latch;

  wire running  = (st == S_RUN);
  wire reg_wr   = running & wr_en;
  wire stop_req = reg_wr & (wr_addr == 2'd0) & wr_data[0];
  wire wake     = lvl_mode ? rel_in : (rel_in & ~rel_q);
  wire wu_tick  = wu_slow ? tick_slow : tick_fast;
  wire gear_hit = (gear == 2'b10) | ((gear == 2'b01) & div[0]) | ((gear == 2'b00) & (&div));

  assign cpu_ce  = running & gear_hit;
  assign stopped = (st == S_STOP);
  assign warming = (st == S_WARM);
  assign port_oe = running | hold_pins;
  assign port_q  = running ? port_d : pin_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      lvl_mode  <= 1'b0;
      hold_pins <= 1'b0;
      rel_q     <= 1'b0;
      gear      <= 2'b00;
      div       <= 2'd0;
      wu_cnt    <= WU_INIT;
      cnt       <= '0;
      pin_latch <= '0;
      wu_slow   <= 1'b0;
      wu_done   <= 1'b0;
      wu_err    <= 1'b0;
    end else begin
      rel_q   <= rel_in;
      wu_done <= 1'b0;
      wu_err  <= 1'b0;
      div     <= running ? div + 2'd1 : 2'd0;
      if (reg_wr) begin
        unique case (wr_addr)
          2'd0: begin
            lvl_mode  <= wr_data[1];
            hold_pins <= wr_data[2];
          end
          2'd1: wu_cnt <= wr_data;
          2'd2: if (wr_data[1:0] != 2'b11) gear <= wr_data[1:0];
          default: ;
        endcase
      end
      unique case (st)
        S_RUN: begin
          if (stop_req) begin
            if (wu_cnt == '0) begin
              wu_err <= 1'b1;
            end else begin
              st        <= S_STOP;
              wu_slow   <= sys_slow;
              pin_latch <= port_d;
            end
          end
        end
        S_STOP: begin
          if (wake) begin
            st  <= S_WARM;
            cnt <= wu_cnt;
          end
        end
        S_WARM: begin
          if (wu_tick) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              st      <= S_RUN;
              wu_done <= 1'b1;
            end
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

endmodule

// File: rtl/stop_wakeup_ctrl_chk.sv
module stop_wakeup_ctrl_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ce,
  input logic          stopped,
  input logic          warming,
  input logic          wu_done,
  input logic          wu_err,
  input logic          wu_slow,
  input logic [PW-1:0] port_q
);

  assert_halt_gates_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped || warming) |-> !cpu_ce);

  assert_states_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stopped && warming));

  assert_warm_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warming) |-> $past(stopped));

  assert_done_ends_warmup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wu_done |-> (!stopped && !warming && $past(warming)));

  assert_refuse_stays_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wu_err |-> (!stopped && !warming));

  assert_pins_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && $past(stopped)) |-> $stable(port_q));

  assert_source_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (warming && $past(stopped || warming)) |-> $stable(wu_slow));

endmodule

bind stop_wakeup_ctrl stop_wakeup_ctrl_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .stopped(stopped),
  .warming(warming), .wu_done(wu_done), .wu_err(wu_err),
  .wu_slow(wu_slow), .port_q(port_q)
);

// File: tb/stop_wakeup_ctrl_tb_top.sv
module stop_wakeup_ctrl_tb_top;
  localparam int PW = 4;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [CW-1:0] wr_data = 0;
  logic rel_in = 0, sys_slow = 0, tick_fast = 0, tick_slow = 0;
  logic [PW-1:0] port_d = 0;
  logic cpu_ce, stopped, warming, wu_done, wu_err, wu_slow, port_oe;
  logic [PW-1:0] port_q;

  int errs = 0, checks = 0, tc = 0;

  stop_wakeup_ctrl #(.PW(PW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rel_in(rel_in), .sys_slow(sys_slow), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .port_d(port_d), .cpu_ce(cpu_ce), .stopped(stopped), .warming(warming),
    .wu_done(wu_done), .wu_err(wu_err), .wu_slow(wu_slow), .port_q(port_q), .port_oe(port_oe)
  );

  always #10 clk = ~clk;

  // reference model: 0 run, 1 stop, 2 warm-up
  int m_st, m_cnt, m_count, m_gear, m_div;
  bit m_lvl, m_hold, m_relq, m_done, m_err, m_slow;
  logic [PW-1:0] m_latch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_count <= 'h66; m_gear <= 0; m_div <= 0;
      m_lvl <= 0; m_hold <= 0; m_relq <= 0; m_done <= 0; m_err <= 0; m_slow <= 0;
      m_latch <= 0;
    end else begin
      m_relq <= rel_in; m_done <= 0; m_err <= 0;
      m_div <= (m_st == 0) ? (m_div + 1) % 4 : 0;
      if (m_st == 0) begin
        if (wr_en && wr_addr == 0) begin
          m_lvl <= wr_data[1]; m_hold <= wr_data[2];
          if (wr_data[0]) begin
            if (m_count == 0) m_err <= 1;
            else begin m_st <= 1; m_slow <= sys_slow; m_latch <= port_d; end
          end
        end
        if (wr_en && wr_addr == 1) m_count <= wr_data;
        if (wr_en && wr_addr == 2 && wr_data[1:0] != 2'b11) m_gear <= wr_data[1:0];
      end else if (m_st == 1) begin
        if (m_lvl ? rel_in : (rel_in && !m_relq)) begin m_st <= 2; m_cnt <= m_count; end
      end else begin
        if (m_slow ? tick_slow : tick_fast) begin
          if (m_cnt == 1) begin m_st <= 0; m_done <= 1; end
          m_cnt <= m_cnt - 1;
        end
      end
    end
  end

  function automatic bit m_ce();
    if (m_st != 0) return 0;
    case (m_gear)
      2: return 1;
      1: return (m_div % 2) == 1;
      default: return m_div == 3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk(cpu_ce == m_ce(), "R8 cpu_ce", cpu_ce, m_ce());
      chk(stopped == (m_st == 1), "R2 stopped", stopped, m_st == 1);
      chk(warming == (m_st == 2), "R6 warming", warming, m_st == 2);
      chk(wu_done == m_done, "R6 wu_done", wu_done, m_done);
      chk(wu_err == m_err, "R7 wu_err", wu_err, m_err);
      chk(port_oe == ((m_st == 0) || m_hold), "R5 port_oe", port_oe, (m_st == 0) || m_hold);
      if (m_st == 0 || m_hold)
        chk(port_q == ((m_st == 0) ? port_d : m_latch), "R5 port_q", port_q,
            (m_st == 0) ? port_d : m_latch);
      chk(wu_slow == m_slow, "R10 wu_slow", wu_slow, m_slow);
    end
  end

  always @(negedge clk) begin
    tc++;
    tick_fast <= (tc % 2) == 0;
    tick_slow <= (tc % 5) == 0;
    port_d    <= PW'(tc * 3);
  end

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    #1;
  endtask

  task automatic ce_count(input int exp, input string req);
    int n = 0;
    repeat (8) begin @(posedge clk); #3; n += cpu_ce; end
    chk(n == exp, req, n, exp);
  endtask

  task automatic wait_run(input string req);
    int dones = 0;
    for (int i = 0; i < 400 && (stopped || warming); i++) begin
      @(posedge clk); #3; dones += wu_done;
    end
    @(posedge clk); #3; dones += wu_done;
    chk(!stopped && !warming && dones == 1, req, dones, 1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!stopped && !warming && !wu_done && !wu_err, "R1 reset state", stopped, 0);
    ce_count(2, "R1 gear div4 at reset");
    wr(2, 1); ce_count(4, "R8 gear 01");
    wr(2, 2); ce_count(8, "R8 gear 10");
    wr(2, 3); ce_count(8, "R9 reserved gear kept");

    // edge wake, pins held, fast source
    wr(1, 4); rel_in = 0; sys_slow = 0;
    wr(0, 8'b0101);
    chk(stopped && !cpu_ce && port_oe, "R2 stop entered", stopped, 1);
    held = port_q;
    repeat (4) @(negedge clk);
    #1 chk(stopped && port_q == held, "R5 pins held", port_q, held);
    @(negedge clk) rel_in = 1;
    wait_run("R6 warm-up ends with one done pulse");

    // edge mode, release already high
    wr(0, 8'b0001);
    repeat (10) @(negedge clk);
    #1 chk(stopped && !warming, "R3 high at entry ignored in edge mode", warming, 0);
    @(negedge clk) rel_in = 0;
    @(negedge clk) rel_in = 1;
    @(negedge clk); #1 chk(warming, "R3 rising edge wakes", warming, 1);
    wait_run("R3 return to run");

    // level mode, release already high
    wr(0, 8'b0011);
    chk(stopped, "R4 entered stop", stopped, 1);
    @(negedge clk); #1 chk(warming, "R4 immediate warm-up", warming, 1);
    wait_run("R4 return to run");

    // zero count refused
    rel_in = 0;
    wr(1, 0); wr(0, 8'b0001);
    chk(!stopped && wu_err, "R7 zero count refused", stopped, 0);
    @(negedge clk); #1 chk(!wu_err, "R7 err single pulse", wu_err, 0);

    // warm-up source forced by entry clock
    wr(1, 3); sys_slow = 1;
    wr(0, 8'b0001);
    chk(wu_slow, "R10 slow source captured", wu_slow, 1);
    @(negedge clk) rel_in = 1;
    wait_run("R10 slow warm-up");
    rel_in = 0; sys_slow = 0;
    wr(0, 8'b1001);
    chk(!wu_slow, "R10 bit3 has no effect", wu_slow, 0);

    // hi-Z policy and writes ignored while halted
    chk(!port_oe, "R5 pins released to hi-Z", port_oe, 0);
    wr(0, 8'b0000);
    chk(!port_oe, "R11 control write ignored in stop", port_oe, 0);
    wr(2, 0); wr(1, 0);
    @(negedge clk) rel_in = 1;
    wait_run("R11 count write ignored");
    ce_count(8, "R11 gear write ignored");
    rel_in = 0;
    wr(0, 8'b0001);
    chk(stopped, "R11 count kept non-zero", stopped, 1);
    @(negedge clk) rel_in = 1;
    wait_run("R6 second warm-up");
    repeat (4) @(negedge clk);
    report();
  end
endmodule